// File: doc/BRIEF.md
# Strobed Latched Parallel Port

This block is a parallel port with a data latch, an output enable that stands in for three-state drivers, and a service-request flop that drives an active-low interrupt line. Two select lines choose the device: one is active low and one is active high. A mode input decides which control loads the latch and what enables the outputs. In output mode the latch is loaded by the select condition and the outputs are always driven. In input mode a peripheral strobe loads the latch, and the outputs are driven only while the device is selected.

A falling strobe edge raises a service request, which pulls the interrupt low. Selecting the device withdraws the request. All control inputs are sampled on a system clock that runs much faster than the control edges, so the latch's level-sensitive behaviour and the strobe edge detection are realised with ordinary flops. The data output and its enable are separate ports. Whoever instantiates the port builds the high-impedance bus from them.

Top module: `strobed_io_port`

## Requirements
- R1: The device counts as selected only when `dsel_n` is 0 and `dsel` is 1. While it is selected, `irq_n` is 0 in the same cycle.
- R2: With `mode` = 1, `dout_en` is 1 whatever the selects are. The latch loads `din` only while the device is selected, whatever `stb` is.
- R3: With `mode` = 0, `dout_en` equals the selected condition. The latch loads `din` only while `stb` is 1, whatever the selects are.
- R4: While the capture control is 1, `dout` takes the value `din` had at the previous rising clock edge.
- R5: While the capture control is 0 and `clr_n` is 1, `dout` keeps its value, even when `din` changes.
- R6: With `clr_n` at 0 and the capture control at 0, `dout` becomes all zeros at the next clock edge. The service request is withdrawn at once, so `irq_n` is 1 unless the device is selected.
- R7: With `clr_n` at 0 and the capture control at 1, the latch still loads `din`, because capture overrides clear.
- R8: A falling edge of `stb` raises the service request. The edge is a 1 in one clock sample followed by a 0 in the next. From the following clock edge `irq_n` is 0, and it stays 0 until the request is withdrawn.
- R9: Any cycle with the device selected withdraws the service request. When a strobe fall arrives in a selected cycle, the withdrawal wins.
- R10: `irq_n` is 1 whenever the request is withdrawn and the device is not selected. The data passes to `dout` without inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| clr_n | input | 1 | Active-low clear of latch and request |
| dsel_n | input | 1 | Active-low select line |
| dsel | input | 1 | Active-high select line |
| mode | input | 1 | 1 = output mode, 0 = input mode |
| stb | input | 1 | Peripheral strobe |
| din | input | WIDTH | Data into the latch |
| dout | output | WIDTH | Latch contents |
| dout_en | output | 1 | Output drive enable (0 = high impedance) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two collisions matter. In the first, a strobe fall and a device select land in the same sampled cycle. In the second, clear and an active capture control arrive together. The bench drives the strobe low in the very cycle it asserts the select. After deselecting, it expects `irq_n` to return to 1, since the withdrawal must win. It also drops `clr_n` while the strobe holds the latch open in input mode, and it expects the fresh `din` rather than zeros on `dout`.

// File: rtl/strobed_io_port.sv
module strobed_io_port #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             dsel_n,
  input  logic             dsel,
  input  logic             mode,
  input  logic             stb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             irq_n
);

  logic             selected;
  logic             capture;
  logic             stb_q;
  logic             stb_fall;
  logic             req;
  logic [WIDTH-1:0] latch_q;

  assign selected = ~dsel_n & dsel;
  assign capture  = mode ? selected : stb;
  assign stb_fall = stb_q & ~stb;

  always_ff @(posedge clk) begin
    if (capture)     latch_q <= din;
    else if (!clr_n) latch_q <= '0;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stb_q <= 1'b0;
      req   <= 1'b0;
    end else begin
      stb_q <= stb;
      if (selected)      req <= 1'b0;
      else if (stb_fall) req <= 1'b1;
    end
  end

  assign dout    = latch_q;
  assign dout_en = mode | selected;
  assign irq_n   = ~(req | selected);

endmodule

// File: rtl/strobed_io_port_chk.sv
module strobed_io_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic             dsel_n,
  input logic             dsel,
  input logic             mode,
  input logic             stb,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic             dout_en,
  input logic             irq_n
);

  logic sel_c, cap_c, stb_d, fall_c;
  assign sel_c  = ~dsel_n & dsel;
  assign cap_c  = mode ? sel_c : stb;
  assign fall_c = stb_d & ~stb;

  always_ff @(posedge clk or negedge clr_n)
    if (!clr_n) stb_d <= 1'b0;
    else        stb_d <= stb;

  AST_SEL_IRQ:   assert property (@(posedge clk) disable iff (!clr_n) sel_c |-> !irq_n);                           // R1
  AST_OUT_EN:    assert property (@(posedge clk) disable iff (!clr_n) mode |-> dout_en);                           // R2
  AST_IN_EN:     assert property (@(posedge clk) disable iff (!clr_n) (!mode && !sel_c) |-> !dout_en);             // R3
  AST_CAPTURE:   assert property (@(posedge clk) disable iff (!clr_n) cap_c |=> (dout == $past(din)));             // R4
  AST_HOLD:      assert property (@(posedge clk) disable iff (!clr_n) !cap_c |=> $stable(dout));                   // R5
  AST_REQ_SET:   assert property (@(posedge clk) disable iff (!clr_n) (fall_c && !sel_c) |=> !irq_n);              // R8
  AST_REQ_KEEP:  assert property (@(posedge clk) disable iff (!clr_n) (!irq_n && !sel_c) |=> !irq_n);              // R8
  AST_SEL_CLR:   assert property (@(posedge clk) disable iff (!clr_n) sel_c |=> (irq_n || sel_c || fall_c));       // R9

endmodule

bind strobed_io_port strobed_io_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/strobed_io_port_test.sv
`timescale 1ns/1ps
module strobed_io_port_test;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0, dsel_n = 1'b1, dsel = 1'b0, mode = 1'b0, stb = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_en, irq_n;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  strobed_io_port #(.WIDTH(8)) uut (
    .clk(clk), .clr_n(clr_n), .dsel_n(dsel_n), .dsel(dsel), .mode(mode),
    .stb(stb), .din(din), .dout(dout), .dout_en(dout_en), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic preload(input logic [7:0] v);
    mode = 1'b1; dsel_n = 1'b0; dsel = 1'b1; stb = 1'b0; din = v;
    cyc();
    mode = 1'b0; dsel_n = 1'b1; dsel = 1'b0;
    cyc();
  endtask

  initial begin
    repeat (2) cyc();
    check("R6 reset irq", irq_n, 1);
    check("R3 reset enable", dout_en, 0);
    clr_n = 1'b1;
    cyc();

    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, b;
      logic sel, cap;
      a = 8'(i * 17 + 3);
      b = ~a;
      preload(a);
      check("R5 preload", dout, a);
      mode = i[0]; stb = i[1]; dsel_n = i[2]; dsel = i[3]; din = b;
      sel = !i[2] && i[3];
      cap = i[0] ? sel : i[1];
      #1;
      check(i[0] ? "R2 enable" : "R3 enable", dout_en, i[0] | sel);
      check("R1 irq", irq_n, !sel);
      cyc();
      check(i[0] ? "R2 capture" : "R3 capture", dout, cap ? b : a);
      check("R10 irq", irq_n, !sel);
      stb = 1'b0; dsel_n = 1'b1; dsel = 1'b0; mode = 1'b0;
      cyc();
    end

    preload(8'h5A);
    mode = 1'b0; stb = 1'b1; din = 8'hC3;
    cyc();
    check("R4 transparent", dout, 8'hC3);
    din = 8'h3C;
    cyc();
    check("R4 follows", dout, 8'h3C);
    stb = 1'b0; din = 8'hFF;
    cyc();
    check("R8 strobe fall irq", irq_n, 0);
    din = 8'h11;
    cyc(); cyc();
    check("R5 hold", dout, 8'h3C);
    check("R8 request stays", irq_n, 0);
    mode = 1'b1; din = 8'h22;
    cyc();
    check("R2 no capture deselected", dout, 8'h3C);
    mode = 1'b0;
    dsel_n = 1'b0; dsel = 1'b1;
    #1 check("R1 selected irq", irq_n, 0);
    cyc();
    dsel_n = 1'b1; dsel = 1'b0;
    #1 check("R9 select clears", irq_n, 1);
    cyc();

    stb = 1'b1;
    cyc();
    stb = 1'b0; dsel_n = 1'b0; dsel = 1'b1;
    cyc();
    dsel_n = 1'b1; dsel = 1'b0;
    #1 check("R9 collision select wins", irq_n, 1);
    cyc();
    check("R9 after collision", irq_n, 1);

    stb = 1'b1; din = 8'h96;
    cyc();
    stb = 1'b0;
    cyc();
    check("R8 set before clear", irq_n, 0);
    clr_n = 1'b0;
    #1 check("R6 clear withdraws request", irq_n, 1);
    cyc();
    check("R6 clear zeroes", dout, 8'h00);
    stb = 1'b1; din = 8'hA7;
    cyc();
    check("R7 capture over clear", dout, 8'hA7);
    stb = 1'b0;
    cyc();
    check("R6 clear after capture", dout, 8'h00);
    clr_n = 1'b1;
    cyc();
    check("R10 idle irq", irq_n, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule